// File: doc/BRIEF.md
# I2C Command-Queue Master

This block is an I2C bus master that software drives through a single command queue. Each queued entry holds a data byte, a read flag and a stop flag. A write entry sends its byte to the target; a read entry fetches one byte from the target into a receive queue. A set stop flag ends the transfer with a STOP condition once that entry's byte is done. The target address comes from a dedicated register, and the address byte is sent automatically after each START.

The block does not generate SCL waveforms. It talks to a separate bit-level engine through a request/acknowledge handshake. It asks that engine for START, STOP, a driven bit or a sampled bit, and the engine reports back with an acknowledge pulse and the sampled SDA level. Software sees a small register file. It holds a data port, status flags, a raw stop-detect interrupt that is cleared by a read, and an enable control with a separate enable-status readback. The enable status only follows the control once the bus transfer in progress has ended.

Top module: `i2c_cq_master`

## Requirements
- R1: A write entry (word written to register 0: bits 7:0 data, bit 8 read flag = 0, bit 9 stop flag) is sent MSB first. When it is the first entry of a transfer, a START and the address byte {target[6:0], 0} come before it. After each byte the master samples one acknowledge bit.
- R2: A read entry (bit 8 = 1) reads 8 bits MSB first and pushes the byte into the receive queue. The master then drives the acknowledge bit: 0 normally, 1 (NACK) when the entry's stop flag is set.
- R3: After an entry with its stop flag set, the master issues a STOP. Every STOP sets the raw stop-detect bit (register 5, bit 0, also on output `irq_stop`). A read of register 6 clears that bit.
- R4: Register 1 reports bit 0 master active, bit 1 transmit queue empty, bit 2 transmit queue not full, bit 3 receive queue not empty and bit 4 abort. It reads 0x6 after reset. Writes to a full transmit queue are dropped.
- R5: A read of register 0 returns the oldest received byte in bits 7:0 and removes it from the receive queue.
- R6: Register 3 holds the enable control (bit 0) and the restart control (bit 1). Register 4 bit 0, the enable status, takes the enable control's value only while the master is idle. No transfer starts while either of them is 0.
- R7: Register 2 holds the 7-bit target address. Writes to it are ignored while the enable status is 1.
- R8: Register 8 reads the constant 0x44570140.
- R9: When the next entry's direction differs from the current one, the master does one of two things. With restart enabled it issues a repeated START and an address byte carrying the new R/W bit, with no STOP. With restart disabled it issues a STOP, then a fresh START and address.
- R10: A NACK on an address byte or a written data byte flushes the transmit queue, issues a STOP and sets the abort bit. A read of register 7 clears the abort bit.
- R11: When the transmit queue runs empty inside a transfer and no stop flag has been seen, the master raises `hold_low` and makes no bit requests until a new entry arrives.
- R12: A bit request stays asserted, with its operation and output bit unchanged, until the engine acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| bit_req | output | 1 | Bit-level operation request |
| bit_op | output | 2 | Operation: 0 START, 1 STOP, 2 drive bit, 3 sample bit |
| bit_out | output | 1 | Bit to drive for operation 2 |
| bit_ack | input | 1 | Engine completed the requested operation |
| bit_in | input | 1 | Sampled SDA level, valid with `bit_ack` for operation 3 |
| hold_low | output | 1 | Transfer stalled on an empty queue; clock held low |
| irq_stop | output | 1 | Raw stop-detect interrupt |

## Verification
The hardest state to reach is the enable status lagging behind the enable control. The control has to be cleared while a transfer is still on the bus, and the status must be read before that transfer ends. The bench slows its bit engine to several cycles per bit and clears the enable right after queueing a two-byte write, which leaves a wide window for the read. NACK aborts and the empty-queue stall also depend on what the far side of the bus does. The bench's target model can refuse a chosen byte, and the bench holds back the stop entry so the stall lasts as long as it needs.

// File: rtl/i2c_cq_pkg.sv
package i2c_cq_pkg;

    // bit-level engine operations
    typedef enum logic [1:0] {
        BIT_START = 2'd0,
        BIT_STOP  = 2'd1,
        BIT_WR    = 2'd2,
        BIT_RD    = 2'd3
    } bit_op_e;

    // symbol-level operations issued by the sequencer
    typedef enum logic [1:0] {
        SYM_START  = 2'd0,
        SYM_STOP   = 2'd1,
        SYM_WRBYTE = 2'd2,
        SYM_RDBYTE = 2'd3
    } sym_e;

    typedef enum logic [2:0] {
        M_IDLE  = 3'd0,
        M_START = 3'd1,
        M_ADDR  = 3'd2,
        M_DATA  = 3'd3,
        M_WAIT  = 3'd4,
        M_STOP  = 3'd5
    } mst_e;

    typedef struct packed {
        logic       stop;
        logic       rd;
        logic [7:0] data;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    localparam logic [3:0] REG_DATA    = 4'h0;
    localparam logic [3:0] REG_STAT    = 4'h1;
    localparam logic [3:0] REG_TAR     = 4'h2;
    localparam logic [3:0] REG_EN      = 4'h3;
    localparam logic [3:0] REG_ENST    = 4'h4;
    localparam logic [3:0] REG_RAW     = 4'h5;
    localparam logic [3:0] REG_CLRSTOP = 4'h6;
    localparam logic [3:0] REG_CLRABT  = 4'h7;
    localparam logic [3:0] REG_COMP    = 4'h8;

    localparam logic [31:0] COMP_TYPE = 32'h4457_0140;

    function automatic bit_op_e sym_bit_op(sym_e kind, logic [3:0] cnt);
        case (kind)
            SYM_START:  return BIT_START;
            SYM_STOP:   return BIT_STOP;
            SYM_WRBYTE: return (cnt < 4'd8) ? BIT_WR : BIT_RD;
            default:    return (cnt < 4'd8) ? BIT_RD : BIT_WR;
        endcase
    endfunction

endpackage

// File: rtl/i2c_cq_fifo.sv
module i2c_cq_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rp    <= '0;
            wp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end
endmodule

// File: rtl/i2c_cq_sym.sv
module i2c_cq_sym
    import i2c_cq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  sym_e       op_kind,
    input  logic [7:0] op_byte,
    input  logic       op_ack,
    output logic       ready,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       ack_seen,
    output logic       bit_req,
    output bit_op_e    bit_op,
    output logic       bit_out,
    input  logic       bit_ack,
    input  logic       bit_in
);
    logic       busy;
    sym_e       kind_q;
    logic [7:0] sh;
    logic [3:0] cnt;
    logic       ack_q;

    assign ready   = !busy;
    assign bit_req = busy;
    assign bit_op  = sym_bit_op(kind_q, cnt);
    assign rx_byte = sh;

    always_comb begin
        bit_out = 1'b0;
        if (kind_q == SYM_WRBYTE) bit_out = sh[7];
        if (kind_q == SYM_RDBYTE) bit_out = ack_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            kind_q   <= SYM_START;
            sh       <= '0;
            cnt      <= '0;
            ack_q    <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy && op_valid) begin
                busy   <= 1'b1;
                kind_q <= op_kind;
                sh     <= op_byte;
                cnt    <= '0;
                ack_q  <= op_ack;
            end else if (busy && bit_ack) begin
                if (kind_q == SYM_START || kind_q == SYM_STOP || cnt == 4'd8) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (kind_q == SYM_WRBYTE) ack_seen <= bit_in;
                end else begin
                    cnt <= cnt + 4'd1;
                    sh  <= (kind_q == SYM_WRBYTE) ? {sh[6:0], 1'b0} : {sh[6:0], bit_in};
                end
            end
        end
    end
endmodule

// File: rtl/i2c_cq_master.sv
module i2c_cq_master
    import i2c_cq_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        bit_req,
    output logic [1:0]  bit_op,
    output logic        bit_out,
    input  logic        bit_ack,
    input  logic        bit_in,
    output logic        hold_low,
    output logic        irq_stop
);
    localparam int TX_CW = $clog2(TX_DEPTH + 1);
    localparam int RX_CW = $clog2(RX_DEPTH + 1);

    mst_e       st;
    logic       launched, cur_dir;
    logic       en_req, en_st, restart_en;
    logic [6:0] tar_q;
    logic       stop_det, abort_q;

    // transmit queue
    logic [CMD_W-1:0] tx_dout;
    logic [TX_CW-1:0] tx_count;
    logic             tx_empty, tx_full, tx_push, tx_pop, tx_flush;
    cmd_t             front;

    // receive queue
    logic [7:0]       rx_dout;
    logic [RX_CW-1:0] rx_count;
    logic             rx_empty, rx_full, rx_push, rx_pop;

    // symbol engine handshake
    logic       op_valid, op_ack, sym_ready, sym_done, ack_seen;
    sym_e       op_kind;
    logic [7:0] op_byte, rx_byte;
    bit_op_e    bit_op_s;

    logic wr_data, rd_data;
    assign wr_data = reg_wr && reg_addr == REG_DATA;
    assign rd_data = reg_rd && reg_addr == REG_DATA;

    assign front    = cmd_t'(tx_dout);
    assign tx_push  = wr_data && !tx_full;
    assign tx_pop   = (st == M_DATA) && sym_done;
    assign tx_flush = sym_done && ack_seen &&
                      (st == M_ADDR || (st == M_DATA && !front.rd));
    assign rx_push  = (st == M_DATA) && sym_done && front.rd;
    assign rx_pop   = rd_data && !rx_empty;
    assign hold_low = (st == M_WAIT);
    assign irq_stop = stop_det;
    assign bit_op   = bit_op_s;

    i2c_cq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .pop(tx_pop), .flush(tx_flush),
        .din(reg_wdata[CMD_W-1:0]), .dout(tx_dout), .count(tx_count),
        .empty(tx_empty), .full(tx_full)
    );

    i2c_cq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .pop(rx_pop), .flush(1'b0),
        .din(rx_byte), .dout(rx_dout), .count(rx_count),
        .empty(rx_empty), .full(rx_full)
    );

    i2c_cq_sym u_sym (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_byte(op_byte), .op_ack(op_ack), .ready(sym_ready), .done(sym_done),
        .rx_byte(rx_byte), .ack_seen(ack_seen), .bit_req(bit_req),
        .bit_op(bit_op_s), .bit_out(bit_out), .bit_ack(bit_ack), .bit_in(bit_in)
    );

    // launch one symbol per state visit
    always_comb begin
        op_valid = 1'b0;
        op_kind  = SYM_START;
        op_byte  = '0;
        op_ack   = 1'b0;
        if (!launched && sym_ready) begin
            case (st)
                M_START: op_valid = 1'b1;
                M_STOP: begin
                    op_valid = 1'b1;
                    op_kind  = SYM_STOP;
                end
                M_ADDR: begin
                    op_valid = 1'b1;
                    op_kind  = SYM_WRBYTE;
                    op_byte  = {tar_q, cur_dir};
                end
                M_DATA: begin
                    if (front.rd == cur_dir && !(front.rd && rx_full)) begin
                        op_valid = 1'b1;
                        op_kind  = front.rd ? SYM_RDBYTE : SYM_WRBYTE;
                        op_byte  = front.data;
                        op_ack   = front.stop;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= M_IDLE;
            launched   <= 1'b0;
            cur_dir    <= 1'b0;
            en_req     <= 1'b0;
            en_st      <= 1'b0;
            restart_en <= 1'b0;
            tar_q      <= '0;
            stop_det   <= 1'b0;
            abort_q    <= 1'b0;
        end else begin
            // register side effects first; hardware events below take priority
            if (reg_wr && reg_addr == REG_TAR && !en_st) tar_q <= reg_wdata[6:0];
            if (reg_wr && reg_addr == REG_EN) begin
                en_req     <= reg_wdata[0];
                restart_en <= reg_wdata[1];
            end
            if (reg_rd && reg_addr == REG_CLRSTOP) stop_det <= 1'b0;
            if (reg_rd && reg_addr == REG_CLRABT)  abort_q  <= 1'b0;

            if (op_valid) launched <= 1'b1;
            if (sym_done) launched <= 1'b0;

            case (st)
                M_IDLE: begin
                    en_st <= en_req;
                    if (en_st && en_req && !tx_empty) begin
                        st      <= M_START;
                        cur_dir <= front.rd;
                    end
                end
                M_START: if (sym_done) st <= M_ADDR;
                M_ADDR: begin
                    if (sym_done) begin
                        if (ack_seen) begin
                            abort_q <= 1'b1;
                            st      <= M_STOP;
                        end else begin
                            st <= M_DATA;
                        end
                    end
                end
                M_DATA: begin
                    if (!launched && front.rd != cur_dir) begin
                        if (restart_en) begin
                            cur_dir <= front.rd;
                            st      <= M_START;
                        end else begin
                            st <= M_STOP;
                        end
                    end else if (sym_done) begin
                        if (!front.rd && ack_seen) begin
                            abort_q <= 1'b1;
                            st      <= M_STOP;
                        end else if (front.stop) begin
                            st <= M_STOP;
                        end else if (tx_count == TX_CW'(1)) begin
                            st <= M_WAIT;
                        end
                    end
                end
                M_WAIT: begin
                    if (!tx_empty)    st <= M_DATA;
                    else if (!en_req) st <= M_STOP;
                end
                M_STOP: begin
                    if (sym_done) begin
                        stop_det <= 1'b1;
                        st       <= M_IDLE;
                    end
                end
                default: st <= M_IDLE;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            REG_DATA:    reg_rdata = {24'd0, rx_dout};
            REG_STAT:    reg_rdata = {27'd0, abort_q, !rx_empty, !tx_full, tx_empty, st != M_IDLE};
            REG_TAR:     reg_rdata = {25'd0, tar_q};
            REG_EN:      reg_rdata = {30'd0, restart_en, en_req};
            REG_ENST:    reg_rdata = {31'd0, en_st};
            REG_RAW:     reg_rdata = {31'd0, stop_det};
            REG_CLRSTOP: reg_rdata = {31'd0, stop_det};
            REG_CLRABT:  reg_rdata = {31'd0, abort_q};
            REG_COMP:    reg_rdata = COMP_TYPE;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_cq_master_chk.sv
module i2c_cq_master_chk
    import i2c_cq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bit_req,
    input logic [1:0] bit_op,
    input logic       bit_out,
    input logic       bit_ack,
    input logic       hold_low,
    input logic       irq_stop,
    input mst_e       st,
    input logic       en_st,
    input logic [6:0] tar_q,
    input logic       abort_q,
    input logic       tx_empty
);
    // R12: request held stable until acknowledged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        bit_req && !bit_ack |=> bit_req && $stable(bit_op) && $stable(bit_out));

    // R3: an acknowledged STOP raises the stop-detect flag two edges later
    p_stop_flag_r3: assert property (@(posedge clk) disable iff (rst)
        bit_req && bit_ack && bit_op == BIT_STOP |-> ##2 irq_stop);

    // R6: enable status moves only while idle
    p_en_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(en_st) |-> $past(st == M_IDLE));

    // R7: target address frozen while enabled
    p_tar_locked_r7: assert property (@(posedge clk) disable iff (rst)
        en_st |=> $stable(tar_q));

    // R10: abort comes with an emptied transmit queue
    p_abort_flush_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(abort_q) |-> tx_empty);

    // R11: no bit traffic while the clock is held low
    p_hold_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        hold_low |-> !bit_req);
endmodule

bind i2c_cq_master i2c_cq_master_chk u_chk (
    .clk(clk), .rst(rst), .bit_req(bit_req), .bit_op(bit_op), .bit_out(bit_out),
    .bit_ack(bit_ack), .hold_low(hold_low), .irq_stop(irq_stop), .st(st),
    .en_st(en_st), .tar_q(tar_q), .abort_q(abort_q), .tx_empty(tx_empty)
);

// File: tb/i2c_cq_master_tb.sv
module i2c_cq_master_tb;
    import i2c_cq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bit_req, bit_out, hold_low, irq_stop;
    logic [1:0]  bit_op;
    logic        bit_ack = 1'b0, bit_in = 1'b0;

    always #10 clk = ~clk;

    i2c_cq_master u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_req(bit_req), .bit_op(bit_op),
        .bit_out(bit_out), .bit_ack(bit_ack), .bit_in(bit_in), .hold_low(hold_low),
        .irq_stop(irq_stop)
    );

    int n_checks = 0, n_fail = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- target and bit engine model ----------------
    int         eng_delay = 0, wcnt = 0, ops_seen = 0, hs_viol = 0;
    logic [1:0] op_at_start;
    logic       out_at_start;
    int         n_start = 0, n_stop = 0, bitpos = 0, byte_no = 0, rd_idx = 0;
    int         nack_at = -1;
    bit         tx_phase = 1'b1, is_addr = 1'b1;
    logic [7:0] sh = '0;
    logic [7:0] got_q[$];
    bit         mack_q[$];

    function automatic logic [7:0] tgt_byte(int i);
        return 8'(i * 37) ^ 8'h5A;
    endfunction

    task automatic serve();
        logic [7:0] tb_byte;
        case (bit_op)
            BIT_START: begin
                n_start++; bitpos = 0; tx_phase = 1'b1; is_addr = 1'b1; byte_no = 0;
            end
            BIT_STOP: n_stop++;
            BIT_WR: begin
                if (tx_phase && bitpos < 8) begin
                    sh = {sh[6:0], bit_out}; bitpos++;
                end else if (!tx_phase && bitpos == 8) begin
                    mack_q.push_back(bit_out); bitpos = 0; rd_idx++;
                end
            end
            default: begin
                if (tx_phase && bitpos == 8) begin
                    got_q.push_back(sh);
                    bit_in = (byte_no == nack_at);
                    if (is_addr) begin tx_phase = !sh[0]; is_addr = 1'b0; end
                    byte_no++; bitpos = 0;
                end else if (!tx_phase && bitpos < 8) begin
                    tb_byte = tgt_byte(rd_idx);
                    bit_in = tb_byte[7 - bitpos]; bitpos++;
                end
            end
        endcase
    endtask

    always begin
        @(negedge clk);
        if (bit_ack) bit_ack = 1'b0;
        else if (bit_req) begin
            if (wcnt == 0) begin op_at_start = bit_op; out_at_start = bit_out; end
            else if (bit_op !== op_at_start || bit_out !== out_at_start) hs_viol++;
            if (wcnt < eng_delay) wcnt++;
            else begin
                wcnt = 0; ops_seen++; serve(); bit_ack = 1'b1;
            end
        end
    end

    // ---------------- register access ----------------
    task automatic reg_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] ent(bit stp, bit rd, logic [7:0] d);
        return {22'd0, stp, rd, d};
    endfunction

    task automatic wait_idle(string tag);
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            reg_read(REG_STAT, s);
            if (s[0] == 1'b0 && s[1] == 1'b1) return;
        end
        check({tag, " idle timeout"}, 32'd1, 32'd0);
    endtask

    task automatic clear_log();
        got_q.delete(); mack_q.delete(); n_start = 0; n_stop = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    localparam logic [6:0] TAR = 7'h52;
    localparam logic [7:0] AW0 = {TAR, 1'b0};
    localparam logic [7:0] AR1 = {TAR, 1'b1};

    initial begin
        logic [31:0] v;
        logic [7:0]  exp_b[$];
        int          exp_rd;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        reg_read(REG_STAT, v);  check("R4 reset status", v, 32'h6);
        reg_read(REG_COMP, v);  check("R8 component type", v, 32'h4457_0140);
        reg_read(REG_ENST, v);  check("R6 reset enable status", v, 32'h0);

        reg_write(REG_TAR, {25'd0, TAR});
        reg_read(REG_TAR, v);   check("R7 target write while disabled", v, {25'd0, TAR});
        reg_write(REG_EN, 32'h3);
        repeat (3) @(negedge clk);
        reg_read(REG_ENST, v);  check("R6 enable status follows when idle", v, 32'h1);
        reg_write(REG_TAR, 32'h11);
        reg_read(REG_TAR, v);   check("R7 target write ignored while enabled", v, {25'd0, TAR});

        // R1 / R3 directed write
        clear_log();
        reg_write(REG_DATA, ent(0, 0, 8'hA1));
        reg_write(REG_DATA, ent(0, 0, 8'hB2));
        reg_write(REG_DATA, ent(1, 0, 8'hC3));
        wait_idle("R1");
        check("R1 byte count", got_q.size(), 4);
        if (got_q.size() == 4) begin
            check("R1 address byte", got_q[0], AW0);
            check("R1 data 0", got_q[1], 8'hA1);
            check("R1 data 1", got_q[2], 8'hB2);
            check("R1 data 2", got_q[3], 8'hC3);
        end
        check("R3 one START", n_start, 1);
        check("R3 one STOP", n_stop, 1);
        reg_read(REG_RAW, v);     check("R3 stop detect set", v, 32'h1);
        check("R3 irq pin", irq_stop, 1'b1);
        reg_read(REG_CLRSTOP, v);
        reg_read(REG_RAW, v);     check("R3 stop detect cleared by read", v, 32'h0);

        // R2 / R5 directed read
        clear_log(); exp_rd = rd_idx;
        reg_write(REG_DATA, ent(0, 1, 8'h00));
        reg_write(REG_DATA, ent(0, 1, 8'h00));
        reg_write(REG_DATA, ent(1, 1, 8'h00));
        wait_idle("R2");
        reg_read(REG_STAT, v);    check("R4 rx not empty", v[3], 1'b1);
        for (int i = 0; i < 3; i++) begin
            reg_read(REG_DATA, v); check("R5 popped byte", v, {24'd0, tgt_byte(exp_rd + i)});
        end
        reg_read(REG_STAT, v);    check("R5 rx drained", v[3], 1'b0);
        check("R2 master ack count", mack_q.size(), 3);
        if (mack_q.size() == 3) begin
            check("R2 ack first", mack_q[0], 1'b0);
            check("R2 ack second", mack_q[1], 1'b0);
            check("R2 nack on stop entry", mack_q[2], 1'b1);
        end
        check("R2 read address byte", got_q.size() > 0 ? got_q[0] : 8'hxx, AR1);

        // R9 restart enabled
        clear_log(); exp_rd = rd_idx;
        reg_write(REG_DATA, ent(0, 0, 8'h10));
        reg_write(REG_DATA, ent(1, 1, 8'h00));
        wait_idle("R9a");
        check("R9 restart START count", n_start, 2);
        check("R9 restart STOP count", n_stop, 1);
        check("R9 restart bytes", got_q.size(), 3);
        if (got_q.size() == 3) check("R9 new direction address", got_q[2], AR1);
        reg_read(REG_DATA, v);    check("R9 read after restart", v, {24'd0, tgt_byte(exp_rd)});

        // R9 restart disabled
        reg_write(REG_EN, 32'h1);
        clear_log(); exp_rd = rd_idx;
        reg_write(REG_DATA, ent(0, 0, 8'h20));
        reg_write(REG_DATA, ent(1, 1, 8'h00));
        wait_idle("R9b");
        check("R9 no-restart START count", n_start, 2);
        check("R9 no-restart STOP count", n_stop, 2);
        reg_read(REG_DATA, v);    check("R9 read after stop-start", v, {24'd0, tgt_byte(exp_rd)});
        reg_write(REG_EN, 32'h3);
        reg_read(REG_CLRSTOP, v);

        // R10 data NACK
        clear_log(); nack_at = 2;
        reg_write(REG_DATA, ent(0, 0, 8'h31));
        reg_write(REG_DATA, ent(0, 0, 8'h32));
        reg_write(REG_DATA, ent(0, 0, 8'h33));
        reg_write(REG_DATA, ent(1, 0, 8'h34));
        wait_idle("R10");
        check("R10 bytes before abort", got_q.size(), 3);
        check("R10 STOP after NACK", n_stop, 1);
        reg_read(REG_STAT, v);    check("R10 abort and flushed status", v, 32'h16);
        reg_read(REG_CLRABT, v);
        reg_read(REG_STAT, v);    check("R10 abort cleared by read", v, 32'h6);

        // R10 address NACK
        clear_log(); nack_at = 0;
        reg_write(REG_DATA, ent(0, 0, 8'h41));
        reg_write(REG_DATA, ent(1, 0, 8'h42));
        wait_idle("R10b");
        check("R10 address NACK bytes", got_q.size(), 1);
        reg_read(REG_STAT, v);    check("R10 address NACK status", v, 32'h16);
        reg_read(REG_CLRABT, v);
        nack_at = -1;

        // R11 stall on empty queue
        clear_log();
        reg_write(REG_DATA, ent(0, 0, 8'h55));
        repeat (120) @(negedge clk);
        check("R11 hold_low raised", hold_low, 1'b1);
        v = ops_seen;
        repeat (50) @(negedge clk);
        check("R11 no bit requests while held", ops_seen, v);
        reg_read(REG_STAT, v);    check("R4 active while held", v[0], 1'b1);
        reg_write(REG_DATA, ent(1, 0, 8'h66));
        wait_idle("R11");
        check("R11 resumed single START", n_start, 1);
        check("R11 resumed bytes", got_q.size(), 3);
        if (got_q.size() == 3) check("R11 resumed byte", got_q[2], 8'h66);

        // R6 enable status lag
        eng_delay = 8;
        reg_write(REG_DATA, ent(0, 0, 8'h71));
        reg_write(REG_DATA, ent(1, 0, 8'h72));
        reg_write(REG_EN, 32'h2);
        reg_read(REG_ENST, v);    check("R6 status held during transfer", v, 32'h1);
        wait_idle("R6");
        repeat (2) @(negedge clk);
        reg_read(REG_ENST, v);    check("R6 status follows after transfer", v, 32'h0);
        eng_delay = 0;

        // R6 no start while disabled, R4 full queue drops
        clear_log();
        for (int i = 0; i < 5; i++) reg_write(REG_DATA, ent(i == 3, 0, 8'(8'h80 + i)));
        repeat (40) @(negedge clk);
        reg_read(REG_STAT, v);    check("R6 no start while disabled", v[0], 1'b0);
        check("R4 full queue status", v[2:1], 2'b00);
        check("R6 no bus traffic while disabled", n_start, 0);
        reg_write(REG_EN, 32'h3);
        wait_idle("R4");
        check("R4 overflow entry dropped", got_q.size(), 5);
        if (got_q.size() == 5) check("R4 last kept entry", got_q[4], 8'h83);

        // constrained random transfers
        for (int it = 0; it < 14; it++) begin
            int n; bit rd;
            n = 1 + int'($urandom % 4); rd = $urandom % 2;
            clear_log(); exp_b.delete(); exp_rd = rd_idx;
            for (int k = 0; k < n; k++) begin
                logic [7:0] d = 8'($urandom);
                exp_b.push_back(d);
                reg_write(REG_DATA, ent(k == n - 1, rd, d));
            end
            wait_idle("rand");
            if (rd) begin
                for (int k = 0; k < n; k++) begin
                    reg_read(REG_DATA, v); check("R2 random read byte", v, {24'd0, tgt_byte(exp_rd + k)});
                end
                check("R2 random ack count", mack_q.size(), n);
            end else begin
                check("R1 random byte count", got_q.size(), n + 1);
                for (int k = 0; k < n && k + 1 < got_q.size(); k++)
                    check("R1 random write byte", got_q[k + 1], exp_b[k]);
            end
            check("R3 random single STOP", n_stop, 1);
        end

        check("R12 handshake stable until ack", hs_viol, 0);
        summary();
        $finish;
    end
endmodule